// File: doc/BRIEF.md
# Two-Port Registered Memory with Port-to-Port Forwarding

A single-clock memory with two independent ports, X and Y. Each port has its own address, write data, write strobe, forwarding control and output enable. Both ports can read, write or forward data in the same cycle. All command inputs are captured on the rising clock edge. Read and forwarded data pass through an output register on each port, so a result appears on the second rising edge after the command is presented.

The forwarding control on one port sends that port's captured write data to the other port's output register. The array is not accessed by that transfer. Forwarding into a port takes priority over a read on that port. Same-address conflicts have fixed outcomes. A read that meets a write returns the earlier contents. When both ports write the same word, port Y's data is kept. The block is active only when both enables are high in the captured cycle. The output enables act combinationally, and a disabled port drives zeros.

The address width defaults to a small size for elaboration. A 32768-word by 36-bit configuration uses AW = 15 and DW = 36.

Top module: `xy_sync_mem`

## Requirements
- R1: After reset both output registers hold zero, so with the output enable high each port's output reads zero.
- R2: A read (write strobe low, no forwarding into the port) returns the stored word on that port's output after the second rising edge following the command.
- R3: With the X forwarding control high, port Y's output shows the X write data of that command two edges later. The array changes only if X's write strobe is also set.
- R4: With the Y forwarding control high, port X's output shows the Y write data of that command two edges later.
- R5: When a port reads and the opposite port forwards to it in the same command, the forwarded data is delivered and the read result is not.
- R6: A port that writes, with no forwarding into it, keeps its previous output value.
- R7: Two reads of the same address in one command return the same stored word on both ports.
- R8: When one port writes an address and the other reads it in the same command, the reader receives the word held before the write.
- R9: When both ports write the same address in one command, only port Y's data is stored.
- R10: If either enable is low in the captured command, no write or forward takes place and both output registers keep their values.
- R11: With a port's output enable low, that port's output is zero within the same cycle. Raising the enable restores the registered value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en_a | input | 1 | First enable, active high, registered |
| en_b | input | 1 | Second enable, active high, registered |
| x_addr | input | AW | Port X address |
| x_din | input | DW | Port X write / forward data |
| x_wr | input | 1 | Port X write strobe |
| x_pass | input | 1 | Forward X data to port Y output |
| x_oe | input | 1 | Port X output enable, combinational |
| x_dout | output | DW | Port X read / forwarded data |
| y_addr | input | AW | Port Y address |
| y_din | input | DW | Port Y write / forward data |
| y_wr | input | 1 | Port Y write strobe |
| y_pass | input | 1 | Forward Y data to port X output |
| y_oe | input | 1 | Port Y output enable, combinational |
| y_dout | output | DW | Port Y read / forwarded data |

## Verification
A wrong selection in an output stage shows on that port two edges after the command. A forwarding or read fault shows as a wrong word. A hold fault during a write or a deselected cycle shows as a changed output. Errors in the array, such as the wrong port winning a write collision or write-before-read ordering, show only when the address is next read. That is one command later, or three edges after the faulty write. A gating fault on the output enable shows within the same cycle.

// File: rtl/xy_mem_pkg.sv
package xy_mem_pkg;
   typedef enum logic [1:0] {
      OSEL_HOLD  = 2'd0,
      OSEL_ARRAY = 2'd1,
      OSEL_PASS  = 2'd2
   } osel_e;
   localparam int NPORT = 2;
endpackage

// File: rtl/xy_port_reg.sv
module xy_port_reg #(
   parameter int AW = 11,
   parameter int DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] din_i,
   input  logic          wr_i,
   input  logic          pass_i,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] din_q,
   output logic          wr_q,
   output logic          pass_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q   <= 1'b0;
         pass_q <= 1'b0;
      end else begin
         wr_q   <= wr_i;
         pass_q <= pass_i;
      end
   end

   always_ff @(posedge clk) begin
      addr_q <= addr_i;
      din_q  <= din_i;
   end
endmodule

// File: rtl/xy_mem_array.sv
module xy_mem_array #(
   parameter int AW    = 11,
   parameter int DW    = 36,
   parameter int NP    = 2
) (
   input  logic                  clk,
   input  logic [NP-1:0]         we,
   input  logic [NP-1:0][AW-1:0] addr,
   input  logic [NP-1:0][DW-1:0] wdat,
   output logic [NP-1:0][DW-1:0] rdat
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // Combinational read of the contents before this edge's writes.
   for (genvar p = 0; p < NP; p++) begin : g_rd
      assign rdat[p] = mem[addr[p]];
   end

   // Ascending order: the highest port index (Y) wins a collision.
   always_ff @(posedge clk) begin
      for (int p = 0; p < NP; p++) begin
         if (we[p]) mem[addr[p]] <= wdat[p];
      end
   end
endmodule

// File: rtl/xy_out_stage.sv
module xy_out_stage
   import xy_mem_pkg::*;
#(
   parameter int DW        = 36,
   parameter bit OUT_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  osel_e         sel,
   input  logic [DW-1:0] pass_d,
   input  logic [DW-1:0] arr_d,
   input  logic          oe,
   output logic [DW-1:0] dout
);
   logic [DW-1:0] q;
   logic [DW-1:0] q_nxt;

   always_comb begin
      unique case (sel)
         OSEL_PASS:  q_nxt = pass_d;
         OSEL_ARRAY: q_nxt = arr_d;
         default:    q_nxt = q;
      endcase
   end

   if (OUT_RESET) begin : g_rst
      always_ff @(posedge clk) begin
         if (!rst_n) q <= '0;
         else        q <= q_nxt;
      end
   end else begin : g_norst
      always_ff @(posedge clk) q <= q_nxt;
   end

   assign dout = oe ? q : '0;
endmodule

// File: rtl/xy_sync_mem.sv
module xy_sync_mem
   import xy_mem_pkg::*;
#(
   parameter int AW        = 11,
   parameter int DW        = 36,
   parameter bit OUT_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_a,
   input  logic          en_b,
   input  logic [AW-1:0] x_addr,
   input  logic [DW-1:0] x_din,
   input  logic          x_wr,
   input  logic          x_pass,
   input  logic          x_oe,
   output logic [DW-1:0] x_dout,
   input  logic [AW-1:0] y_addr,
   input  logic [DW-1:0] y_din,
   input  logic          y_wr,
   input  logic          y_pass,
   input  logic          y_oe,
   output logic [DW-1:0] y_dout
);
   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("xy_sync_mem: AW out of range");
   end
   if (DW < 1) begin : g_bad_dw
      $error("xy_sync_mem: DW must be positive");
   end

   logic [NPORT-1:0][AW-1:0] a_in, a_q;
   logic [NPORT-1:0][DW-1:0] d_in, d_q, rd, dout;
   logic [NPORT-1:0]         w_in, w_q, p_in, p_q, oe_in, we;
   osel_e                    osel [NPORT];
   logic                     en_a_q, en_b_q, active;

   assign a_in  = {y_addr, x_addr};
   assign d_in  = {y_din,  x_din};
   assign w_in  = {y_wr,   x_wr};
   assign p_in  = {y_pass, x_pass};
   assign oe_in = {y_oe,   x_oe};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_a_q <= 1'b0;
         en_b_q <= 1'b0;
      end else begin
         en_a_q <= en_a;
         en_b_q <= en_b;
      end
   end

   assign active = en_a_q & en_b_q;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      localparam int OTHER = NPORT - 1 - p;

      xy_port_reg #(.AW(AW), .DW(DW)) u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .addr_i (a_in[p]),
         .din_i  (d_in[p]),
         .wr_i   (w_in[p]),
         .pass_i (p_in[p]),
         .addr_q (a_q[p]),
         .din_q  (d_q[p]),
         .wr_q   (w_q[p]),
         .pass_q (p_q[p])
      );

      assign we[p] = active & w_q[p];

      always_comb begin
         if (!active)          osel[p] = OSEL_HOLD;
         else if (p_q[OTHER])  osel[p] = OSEL_PASS;
         else if (!w_q[p])     osel[p] = OSEL_ARRAY;
         else                  osel[p] = OSEL_HOLD;
      end

      xy_out_stage #(.DW(DW), .OUT_RESET(OUT_RESET)) u_out (
         .clk    (clk),
         .rst_n  (rst_n),
         .sel    (osel[p]),
         .pass_d (d_q[OTHER]),
         .arr_d  (rd[p]),
         .oe     (oe_in[p]),
         .dout   (dout[p])
      );
   end

   xy_mem_array #(.AW(AW), .DW(DW), .NP(NPORT)) u_array (
      .clk  (clk),
      .we   (we),
      .addr (a_q),
      .wdat (d_q),
      .rdat (rd)
   );

   assign x_dout = dout[0];
   assign y_dout = dout[1];
endmodule

// File: rtl/xy_sync_mem_chk.sv
module xy_sync_mem_chk #(
   parameter int AW = 11,
   parameter int DW = 36
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en_a,
   input logic          en_b,
   input logic [AW-1:0] x_addr,
   input logic [DW-1:0] x_din,
   input logic          x_wr,
   input logic          x_pass,
   input logic          x_oe,
   input logic [DW-1:0] x_dout,
   input logic [AW-1:0] y_addr,
   input logic [DW-1:0] y_din,
   input logic          y_wr,
   input logic          y_pass,
   input logic          y_oe,
   input logic [DW-1:0] y_dout
);
   logic [1:0] age;
   logic       sel;

   always_ff @(posedge clk) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   assign sel = en_a && en_b;

   AST_PASS_X_TO_Y: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(sel && x_pass, 2) && y_oe) |-> y_dout == $past(x_din, 2)); // R3

   AST_PASS_Y_TO_X: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(sel && y_pass, 2) && x_oe) |-> x_dout == $past(y_din, 2)); // R4

   AST_WRITER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(sel && x_wr && !y_pass, 2) && x_oe && $past(x_oe))
      |-> x_dout == $past(x_dout)); // R6

   AST_SAME_READ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(sel && !x_wr && !y_wr && !x_pass && !y_pass
                            && x_addr == y_addr, 2) && x_oe && y_oe)
      |-> x_dout == y_dout); // R7

   AST_IDLE_HOLD_X: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && !$past(sel, 2) && x_oe && $past(x_oe))
      |-> x_dout == $past(x_dout)); // R10

   AST_IDLE_HOLD_Y: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && !$past(sel, 2) && y_oe && $past(y_oe))
      |-> y_dout == $past(y_dout)); // R10
endmodule

bind xy_sync_mem xy_sync_mem_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .en_a   (en_a),
   .en_b   (en_b),
   .x_addr (x_addr),
   .x_din  (x_din),
   .x_wr   (x_wr),
   .x_pass (x_pass),
   .x_oe   (x_oe),
   .x_dout (x_dout),
   .y_addr (y_addr),
   .y_din  (y_din),
   .y_wr   (y_wr),
   .y_pass (y_pass),
   .y_oe   (y_oe),
   .y_dout (y_dout)
);

// File: tb/xy_sync_mem_tb.sv
module xy_sync_mem_tb;
   localparam int PER = 10;
   localparam int AW  = 11;
   localparam int DW  = 36;

   typedef struct {
      logic [DW-1:0] qx;
      logic [DW-1:0] qy;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en_a = 1'b0, en_b = 1'b0;
   logic [AW-1:0] x_addr = '0, y_addr = '0;
   logic [DW-1:0] x_din = '0, y_din = '0;
   logic          x_wr = 1'b0, y_wr = 1'b0, x_pass = 1'b0, y_pass = 1'b0;
   logic          x_oe = 1'b1, y_oe = 1'b1;
   logic [DW-1:0] x_dout, y_dout;

   int            n_run = 0;
   int            n_fail = 0;
   bit            done = 1'b0;
   exp_t          sb [$];
   logic [DW-1:0] model [int];
   logic [DW-1:0] mq_x = '0, mq_y = '0;

   always #(PER/2) clk = ~clk;

   xy_sync_mem #(.AW(AW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b),
      .x_addr(x_addr), .x_din(x_din), .x_wr(x_wr), .x_pass(x_pass),
      .x_oe(x_oe), .x_dout(x_dout),
      .y_addr(y_addr), .y_din(y_din), .y_wr(y_wr), .y_pass(y_pass),
      .y_oe(y_oe), .y_dout(y_dout)
   );

   task automatic check(input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: present one command and push the expected output registers.
   task automatic beat(input logic ea, input logic eb,
                       input int ax, input logic [DW-1:0] dx,
                       input logic wx, input logic px,
                       input int ay, input logic [DW-1:0] dy,
                       input logic wy, input logic py, input string tag);
      exp_t e;
      @(negedge clk);
      en_a = ea; en_b = eb;
      x_addr = AW'(ax); x_din = dx; x_wr = wx; x_pass = px;
      y_addr = AW'(ay); y_din = dy; y_wr = wy; y_pass = py;
      if (ea && eb) begin
         logic [DW-1:0] nx, ny;
         nx = mq_x; ny = mq_y;
         if (py)       nx = dy;
         else if (!wx) nx = model[ax];
         if (px)       ny = dx;
         else if (!wy) ny = model[ay];
         mq_x = nx; mq_y = ny;
         if (wx) model[ax] = dx;
         if (wy) model[ay] = dy;   // R9: Y stored last
      end
      e.qx = mq_x; e.qy = mq_y; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input string tag);
      beat(1'b0, 1'b0, 0, '0, 1'b0, 1'b0, 0, '0, 1'b0, 1'b0, tag);
   endtask

   // Monitor: each entry leaves the queue two edges after it was pushed.
   initial begin
      forever begin
         @(posedge clk);
         #(PER/4);
         while (sb.size() >= 2) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " x"}, x_dout, x_oe ? e.qx : '0);
            check({e.tag, " y"}, y_dout, y_oe ? e.qy : '0);
         end
      end
   end

   initial begin
      #(PER * 200000);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 x", x_dout, '0);
      check("R1 y", y_dout, '0);

      // R6: writers keep their outputs
      beat(1, 1, 5, 36'hA_1111_0005, 1, 0, 9, 36'hB_2222_0009, 1, 0, "R6");
      // R2: cross reads
      beat(1, 1, 9, '0, 0, 0, 5, '0, 0, 0, "R2");
      // R3 and R5: X forwards to Y, Y's read is overridden
      beat(1, 1, 9, 36'hC_3333_0000, 0, 1, 5, '0, 0, 0, "R3_R5");
      // R4 and R5: Y forwards to X
      beat(1, 1, 5, '0, 0, 0, 9, 36'hD_4444_0000, 0, 1, "R4_R5");
      // R3: forwarding did not alter address 9 or 5; R7 same-address reads
      beat(1, 1, 5, '0, 0, 0, 5, '0, 0, 0, "R7");
      beat(1, 1, 9, '0, 0, 0, 9, '0, 0, 0, "R3_R7");
      // R8: X writes 9, Y reads 9 and gets the old word
      beat(1, 1, 9, 36'hE_5555_0009, 1, 0, 9, '0, 0, 0, "R8");
      beat(1, 1, 9, '0, 0, 0, 9, '0, 0, 0, "R8");
      // R9: both write 12, Y wins
      beat(1, 1, 12, 36'hF_6666_000C, 1, 0, 12, 36'h7_7777_000C, 1, 0, "R9");
      beat(1, 1, 12, '0, 0, 0, 12, '0, 0, 0, "R9");
      // R6 with forward into writer: forward wins
      beat(1, 1, 20, 36'h1_0101_0014, 1, 0, 21, 36'h2_0202_0015, 0, 1, "R6_R5");
      // R10: one enable low each way, with write and forward requested
      beat(0, 1, 12, 36'h3_0303_0000, 1, 1, 12, 36'h4_0404_0000, 1, 1, "R10");
      beat(1, 0, 12, 36'h5_0505_0000, 1, 1, 12, 36'h6_0606_0000, 1, 1, "R10");
      beat(1, 1, 12, '0, 0, 0, 20, '0, 0, 0, "R10");
      idle("R10");
      idle("R10");

      // R11: output enable gating, same cycle
      @(negedge clk);
      x_oe = 1'b0;
      #1 check("R11 x off", x_dout, '0);
      y_oe = 1'b0;
      #1 check("R11 y off", y_dout, '0);
      idle("R11");
      @(negedge clk);
      x_oe = 1'b1; y_oe = 1'b1;
      #1 check("R11 x on", x_dout, mq_x);
      check("R11 y on", y_dout, mq_y);
      idle("R11");
      idle("R11");
      idle("R11");
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule